// File: doc/BRIEF.md
# Sleep Control and APM Command Port

This block holds the power-management control word and a pair of byte-wide advanced-power-management ports (a command byte and a status byte). Software writes the control word through a simple register bus. When such a write carries the sleep-trigger bit, the block decodes the three-bit sleep type in the same word and emits a one-clock request pulse toward the platform: power-off, suspend, or hibernate. The trigger bit acts only as a strobe and is never kept in the stored word.

Writes to the command byte have two side effects. Two reserved command codes turn the interrupt-routing enable (bit 0 of the control word) on or off. When the SMI strap is tied high, every command write also produces a one-clock SMI pulse. The hibernate sleep-type value comes in on a configuration input, so a platform can pick which type code means hibernate. The bus is a plain single-cycle write strobe with a combinational read. It has no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `pm_sleep_ctrl`

## Requirements
- R1: After reset the control word, the command byte and the status byte read 0, and sci_en, req_off, req_suspend, req_hibernate and smi_req are low.
- R2: A write to the control address (default 0x04) stores all 16 data bits except bit 13, which is stored as 0, so a read of the control word never shows bit 13 set.
- R3: A control write with bit 13 set and sleep type (bits 12:10) equal to 0 makes req_off high for exactly the one clock after the write.
- R4: A control write with bit 13 set and sleep type 1 makes req_suspend high for exactly the one clock after the write.
- R5: A control write with bit 13 set and a sleep type other than 0 or 1 that equals cfg_hib_type makes req_hibernate high for the one clock after the write. Any other type produces no pulse. At most one request pulse is high at a time.
- R6: A control write with bit 13 clear produces no request pulse, whatever bits 12:10 hold.
- R7: The command byte (address 0xB2) and the status byte (address 0xB3) store bits 7:0 of a write and read back zero-extended. Data bits 15:8 are ignored.
- R8: Writing 0xF1 to the command byte sets control bit 0, and writing 0xF0 clears it. All other control bits are unchanged. sci_en always equals control bit 0.
- R9: A command-byte write with cfg_smi_en high makes smi_req high for exactly the one clock after the write. With cfg_smi_en low, and for any status-byte write, smi_req stays low.
- R10: A write to any other address changes no register, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, accepted in the cycle it is high |
| bus_addr | input | 8 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| cfg_hib_type | input | 3 | Sleep type code that means hibernate |
| cfg_smi_en | input | 1 | Strap that allows command writes to raise SMI |
| sci_en | output | 1 | Current value of control bit 0 |
| req_off | output | 1 | One-clock soft power-off request |
| req_suspend | output | 1 | One-clock suspend request |
| req_hibernate | output | 1 | One-clock hibernate-then-off request |
| smi_req | output | 1 | One-clock SMI request |

## Verification
The bench builds the block with its default parameters: control word at 0x04, 16-bit data, trigger at bit 13 and the sleep type at bits 12:10. This puts the sleep-type field and the trigger bit at the positions the requirements name, and leaves the whole 8-bit address space open for probing unmapped addresses. The bench drives cfg_hib_type and cfg_smi_en per vector. This brings within reach the case where a hibernate value of 0 or 1 must not override power-off or suspend, as well as a matching type without the trigger bit, and SMI behaviour with the strap both high and low.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;

  typedef enum logic [1:0] {
    SLP_NONE      = 2'd0,
    SLP_OFF       = 2'd1,
    SLP_SUSPEND   = 2'd2,
    SLP_HIBERNATE = 2'd3
  } sleep_req_e;

  // Map a triggered sleep type onto a request kind.
  function automatic sleep_req_e classify_sleep(input logic [2:0] typ,
                                                input logic [2:0] hib);
    if (typ == 3'd0)      return SLP_OFF;
    else if (typ == 3'd1) return SLP_SUSPEND;
    else if (typ == hib)  return SLP_HIBERNATE;
    else                  return SLP_NONE;
  endfunction

endpackage

// File: rtl/pm_sleep_decode.sv
module pm_sleep_decode
  import pm_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic [2:0] slp_typ,
  input  logic [2:0] hib_typ,
  output logic       req_off,
  output logic       req_suspend,
  output logic       req_hibernate
);

  sleep_req_e kind;

  always_comb begin
    kind = trig ? classify_sleep(slp_typ, hib_typ) : SLP_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_off       <= 1'b0;
      req_suspend   <= 1'b0;
      req_hibernate <= 1'b0;
    end else begin
      req_off       <= (kind == SLP_OFF);
      req_suspend   <= (kind == SLP_SUSPEND);
      req_hibernate <= (kind == SLP_HIBERNATE);
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_off, req_suspend, req_hibernate})) else $error("multiple requests"); // R5

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_off |-> $past(trig && slp_typ == 3'd0)) else $error("spurious power-off"); // R3

  AST_SUSPEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_suspend |-> $past(trig && slp_typ == 3'd1)) else $error("spurious suspend"); // R4

endmodule

// File: rtl/pm_apm_port.sv
module pm_apm_port #(
  parameter logic [7:0] SCI_ON_CMD  = 8'hF1,
  parameter logic [7:0] SCI_OFF_CMD = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       sts_wr,
  input  logic [7:0] wbyte,
  input  logic       smi_allow,
  output logic [7:0] cmd_q,
  output logic [7:0] sts_q,
  output logic       sci_set,
  output logic       sci_clr,
  output logic       smi_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      sts_q   <= '0;
      smi_req <= 1'b0;
    end else begin
      if (cmd_wr) cmd_q <= wbyte;
      if (sts_wr) sts_q <= wbyte;
      smi_req <= cmd_wr && smi_allow;
    end
  end

  assign sci_set = cmd_wr && (wbyte == SCI_ON_CMD);
  assign sci_clr = cmd_wr && (wbyte == SCI_OFF_CMD);

  AST_SMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(cmd_wr && smi_allow)) else $error("smi without command write"); // R9

  AST_SMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !cmd_wr) |=> !smi_req) else $error("status write raised smi"); // R9

endmodule

// File: rtl/pm_sleep_ctrl.sv
module pm_sleep_ctrl #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h04,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'hB2,
  parameter logic [ADDR_W-1:0] STS_ADDR  = 8'hB3,
  parameter int              SLP_EN_BIT  = 13,
  parameter int              SLP_TYP_LSB = 10,
  parameter int              SCI_BIT     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [2:0]        cfg_hib_type,
  input  logic              cfg_smi_en,
  output logic              sci_en,
  output logic              req_off,
  output logic              req_suspend,
  output logic              req_hibernate,
  output logic              smi_req
);

  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << SLP_EN_BIT);

  logic [DATA_W-1:0] ctrl_q;
  logic [7:0]        cmd_q, sts_q;
  logic              ctrl_wr, cmd_wr, sts_wr;
  logic              sci_set, sci_clr;

  assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
  assign cmd_wr  = bus_wr && (bus_addr == CMD_ADDR);
  assign sts_wr  = bus_wr && (bus_addr == STS_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= bus_wdata & STORE_MASK;
    end else if (sci_set) begin
      ctrl_q[SCI_BIT] <= 1'b1;
    end else if (sci_clr) begin
      ctrl_q[SCI_BIT] <= 1'b0;
    end
  end

  assign sci_en = ctrl_q[SCI_BIT];

  always_comb begin
    if (bus_addr == CTRL_ADDR)     bus_rdata = ctrl_q;
    else if (bus_addr == CMD_ADDR) bus_rdata = DATA_W'(cmd_q);
    else if (bus_addr == STS_ADDR) bus_rdata = DATA_W'(sts_q);
    else                           bus_rdata = '0;
  end

  pm_sleep_decode u_decode (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig         (ctrl_wr && bus_wdata[SLP_EN_BIT]),
    .slp_typ      (bus_wdata[SLP_TYP_LSB +: 3]),
    .hib_typ      (cfg_hib_type),
    .req_off      (req_off),
    .req_suspend  (req_suspend),
    .req_hibernate(req_hibernate)
  );

  pm_apm_port u_apm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .sts_wr   (sts_wr),
    .wbyte    (bus_wdata[7:0]),
    .smi_allow(cfg_smi_en),
    .cmd_q    (cmd_q),
    .sts_q    (sts_q),
    .sci_set  (sci_set),
    .sci_clr  (sci_clr),
    .smi_req  (smi_req)
  );

  AST_TRIGGER_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_ADDR) |-> !bus_rdata[SLP_EN_BIT]) else $error("trigger bit visible"); // R2

  AST_SCI_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[7:0] == 8'hF1) |=> sci_en) else $error("sci not set"); // R8

  AST_SCI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[7:0] == 8'hF0) |=> !sci_en) else $error("sci not cleared"); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != CTRL_ADDR && bus_addr != CMD_ADDR && bus_addr != STS_ADDR)
      |-> (bus_rdata == '0)) else $error("unmapped read nonzero"); // R10

endmodule

// File: tb/pm_sleep_ctrl_tb.sv
module pm_sleep_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic [2:0]  cfg_hib_type = 3'd0;
  logic        cfg_smi_en = 1'b0;
  logic        sci_en, req_off, req_suspend, req_hibernate, smi_req;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  pm_sleep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_hib_type(cfg_hib_type),
    .cfg_smi_en(cfg_smi_en), .sci_en(sci_en), .req_off(req_off),
    .req_suspend(req_suspend), .req_hibernate(req_hibernate), .smi_req(smi_req)
  );

  // Vector: addr(8) wdata(16) hib(3) smi(1) exp_rd(16) exp_pulse(4) = 48 bits
  // exp_pulse order: {off, suspend, hibernate, smi}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {8'h04, 16'h0005, 3'd5, 1'b0, 16'h0005, 4'b0000}, // R2 R6
    {8'h04, 16'h2001, 3'd5, 1'b0, 16'h0001, 4'b1000}, // R3
    {8'h04, 16'h2400, 3'd5, 1'b0, 16'h0400, 4'b0100}, // R4
    {8'h04, 16'h3400, 3'd5, 1'b0, 16'h1400, 4'b0010}, // R5 match
    {8'h04, 16'h3400, 3'd6, 1'b0, 16'h1400, 4'b0000}, // R5 no match
    {8'h04, 16'h2000, 3'd0, 1'b0, 16'h0000, 4'b1000}, // R5 hib=0 keeps off
    {8'hB2, 16'h1234, 3'd0, 1'b0, 16'h0034, 4'b0000}, // R7 R9 strap low
    {8'hB3, 16'hAB77, 3'd0, 1'b1, 16'h0077, 4'b0000}, // R7 R9 status no smi
    {8'hB2, 16'h0012, 3'd0, 1'b1, 16'h0012, 4'b0001}, // R9
    {8'h04, 16'hDFFF, 3'd7, 1'b0, 16'hDFFF, 4'b0000}  // R6 type 7 untriggered
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Write at one edge; returns at the negedge after it with the strobe dropped.
  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [15:0] pulses();
    return {12'h0, req_off, req_suspend, req_hibernate, smi_req};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_addr = 8'h04; #1 check("R1 ctrl", bus_rdata, 16'h0);
    bus_addr = 8'hB2; #1 check("R1 cmd", bus_rdata, 16'h0);
    bus_addr = 8'hB3; #1 check("R1 sts", bus_rdata, 16'h0);
    check("R1 outputs", {11'h0, sci_en, pulses()[3:0]}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {11'h0, sci_en, pulses()[3:0]}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      cfg_hib_type = VEC[i][23:21];
      cfg_smi_en   = VEC[i][20];
      do_write(VEC[i][47:40], VEC[i][39:24]);
      check($sformatf("R3/R4/R5/R9 pulses vec%0d", i), pulses(), {12'h0, VEC[i][3:0]});
      check($sformatf("R2/R7 readback vec%0d", i), bus_rdata, VEC[i][19:4]);
      @(negedge clk);
      check($sformatf("R3/R4/R5/R9 single-cycle vec%0d", i), pulses(), 16'h0);
    end

    // R8: SCI enable commands act on bit 0 only
    cfg_smi_en = 1'b0;
    do_write(8'h04, 16'h0082);
    do_write(8'hB2, 16'h00F1);
    bus_addr = 8'h04; #1 check("R8 set", bus_rdata, 16'h0083);
    check("R8 sci_en high", {15'h0, sci_en}, 16'h1);
    do_write(8'hB2, 16'h00F0);
    bus_addr = 8'h04; #1 check("R8 clear", bus_rdata, 16'h0082);
    check("R8 sci_en low", {15'h0, sci_en}, 16'h0);
    do_write(8'hB2, 16'hFF55);
    bus_addr = 8'h04; #1 check("R8 other code no effect", bus_rdata, 16'h0082);

    // R10: unmapped address
    do_write(8'h10, 16'hFFFF);
    check("R10 no pulse", pulses(), 16'h0);
    #1 check("R10 read zero", bus_rdata, 16'h0);
    bus_addr = 8'h04; #1 check("R10 ctrl unchanged", bus_rdata, 16'h0082);
    bus_addr = 8'hB3; #1 check("R10 sts unchanged", bus_rdata, 16'h0077);

    // R3 back-to-back triggers give one pulse each
    do_write(8'h04, 16'h2000);
    check("R3 first", pulses(), 16'h8);
    do_write(8'h04, 16'h0000);
    check("R3 second untriggered", pulses(), 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule